// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It captures requests from eight input lines into a pending register. Each line is captured either on a rising edge or by following its level. The block picks the most urgent request that is unmasked and not held back by a handler already running, and raises `int_o` while such a request exists. An acknowledge strobe, or a poll, takes the winner: its pending bit is cleared and its in-service bit is set. The acknowledge also returns a vector made of a software type base and the level number. The poll returns a status byte instead.

Priority runs as a ring. A pointer names the level with the lowest priority, and the level after it in the ring has the highest. Eight three-bit commands adjust the in-service register and the ring. Some clear the in-service bit, either at the most urgent level or at a named level. Some move the pointer, either to a named level or to the level that was just cleared. Two commands turn on or off rotation on automatic end-of-interrupt. The auto end-of-interrupt input stops acknowledges from leaving an in-service bit set. The special-mask input lets lower levels interrupt an active handler.

Top module: `irq_resolver_core`

## Requirements
- R1: After reset the pending and in-service registers are empty, the pointer is 7 so IR0 is most urgent and IR7 least, rotation on auto-EOI is off, and `int_o`, `vector_o` and `poll_o` are zero.
- R2: With `level_mode_i` low, a pending bit is set only on a 0-to-1 change of its input line. A line held high after its acknowledge raises no new request.
- R3: With `level_mode_i` high, the pending register copies `irq_i` on every clock, and an acknowledge does not clear it.
- R4: `int_o` is high only when an eligible request exists. A `mask_i` bit of 1 removes that level from eligibility.
- R5: Without special mask, a request is eligible only if it is more urgent than the most urgent in-service level. A level that is in service is never eligible.
- R6: With `spec_mask_i` high, every pending, unmasked level whose own in-service bit is clear is eligible.
- R7: On `ack_i`, the winner's pending bit clears and its in-service bit sets. On the next cycle `vector_o` = {`type_base_i`, level}. With no winner, `vector_o` = {`type_base_i`, 3'b111} and the state is unchanged.
- R8: When `cmd_valid_i` is high, `cmd_i` 3'b001 clears the most urgent in-service bit and 3'b011 clears the bit at `cmd_lvl_i`. Code 3'b010 changes nothing.
- R9: Code 3'b101 clears the most urgent in-service bit and moves the pointer to that level. Code 3'b111 clears the bit at `cmd_lvl_i` and moves the pointer there. Code 3'b110 only moves the pointer to `cmd_lvl_i`. After a move the pointer's level is least urgent, and the next level up the ring, modulo 8, is most urgent.
- R10: With `auto_eoi_i` high, an acknowledge or poll sets no in-service bit. Code 3'b100 turns on rotation on auto-EOI and code 3'b000 turns it off. While it is on, each such acknowledge moves the pointer to the acknowledged level.
- R11: On `poll_i`, `poll_o` becomes {1, 4'b0, level} on the next cycle when a winner exists and 8'h00 when none does. A poll with a winner updates state exactly as an acknowledge does.
- R12: When a command and an acknowledge fall in the same cycle, both take effect. A pointer move by the command overrides the one from auto-EOI rotation, and the acknowledge sets the winner's in-service bit even if the command clears that same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request lines, bit n is level n |
| mask_i | input | 8 | Level mask, 1 = masked |
| level_mode_i | input | 1 | 1 = level capture, 0 = rising-edge capture |
| auto_eoi_i | input | 1 | Automatic end of interrupt |
| spec_mask_i | input | 1 | Special mask mode |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_i | input | 3 | Command code (rotate, select, end-of-interrupt) |
| cmd_lvl_i | input | 3 | Level addressed by the command |
| type_base_i | input | 5 | Upper bits of the vector |
| ack_i | input | 1 | Acknowledge strobe |
| poll_i | input | 1 | Poll strobe |
| int_o | output | 1 | Eligible request present |
| vector_o | output | 8 | Vector of the last acknowledge |
| poll_o | output | 8 | Result of the last poll |

## Verification
The assertions check on every cycle that edge capture sets a pending bit and level capture copies the lines. They also check that `int_o` never rises without an unmasked pending bit and that the nested-mode winner outranks the active handler. The remaining cycle checks cover the special-mask winner, acknowledges that set an in-service bit, auto-EOI acknowledges that set none, the pointer move on set-priority, and an empty poll.

Only the bench's scenarios show how the ring order changes across a sequence of rotations. The same holds for end-of-interrupt on the right level, a held edge line staying quiet after its acknowledge, and the priority between a command and an acknowledge in the same cycle. The bench compares these against a behavioural model on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    OP_AROT_OFF = 3'b000,
    OP_NS_EOI   = 3'b001,
    OP_NOP      = 3'b010,
    OP_SP_EOI   = 3'b011,
    OP_AROT_ON  = 3'b100,
    OP_ROT_NS   = 3'b101,
    OP_SET_LOW  = 3'b110,
    OP_ROT_SP   = 3'b111
  } prio_op_e;
endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] low_i,
  output logic         found_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rank_o
);
  logic [W-1:0] top;
  logic [N-1:0] rot;

  assign top = low_i + W'(1);

  // rot[0] is the most urgent level
  for (genvar r = 0; r < N; r++) begin : g_rot
    assign rot[r] = vec_i[top + W'(r)];
  end

  always_comb begin
    found_o = 1'b0;
    rank_o  = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (rot[r]) begin
        found_o = 1'b1;
        rank_o  = W'(r);
      end
    end
  end

  assign lvl_o = top + rank_o;
endmodule

// File: rtl/irq_request_reg.sv
module irq_request_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         level_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irr_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= irq_i;
      irr_q  <= level_mode_i ? irq_i : ((irr_q & ~clr_i) | (irq_i & ~prev_q));
    end
  end

  assign irr_o = irr_q;

  // R2
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_mode_i |=> ((irr_q & $past(irq_i & ~prev_q)) == $past(irq_i & ~prev_q)));

  // R3
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_mode_i |=> (irr_q == $past(irq_i)));
endmodule

// File: rtl/irq_service_ctrl.sv
module irq_service_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N),
  localparam int unsigned TB_W = 8 - W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_i,
  input  logic [W-1:0]    cmd_lvl_i,
  input  logic            ack_i,
  input  logic            poll_i,
  input  logic            auto_eoi_i,
  input  logic [TB_W-1:0] type_base_i,
  input  logic            win_found_i,
  input  logic [W-1:0]    win_lvl_i,
  input  logic            isr_found_i,
  input  logic [W-1:0]    isr_lvl_i,
  output logic [N-1:0]    isr_o,
  output logic [W-1:0]    low_o,
  output logic [N-1:0]    irr_clr_o,
  output logic [7:0]      vector_o,
  output logic [7:0]      poll_o
);
  logic [N-1:0] isr_q, isr_clr, win_oh, cmd_oh, top_oh;
  logic [W-1:0] low_q, low_cmd, low_d;
  logic         low_cmd_we, arot_q, arot_set, arot_clr, take;
  logic [7:0]   vector_q, poll_q;

  assign take   = (ack_i | poll_i) & win_found_i;
  assign win_oh = take ? (N'(1) << win_lvl_i) : '0;
  assign cmd_oh = N'(1) << cmd_lvl_i;
  assign top_oh = N'(1) << isr_lvl_i;

  always_comb begin
    isr_clr    = '0;
    low_cmd_we = 1'b0;
    low_cmd    = '0;
    arot_set   = 1'b0;
    arot_clr   = 1'b0;
    if (cmd_valid_i) begin
      case (prio_op_e'(cmd_i))
        OP_NS_EOI: if (isr_found_i) isr_clr = top_oh;
        OP_SP_EOI: isr_clr = cmd_oh;
        OP_ROT_NS: begin
          if (isr_found_i) begin
            isr_clr    = top_oh;
            low_cmd_we = 1'b1;
            low_cmd    = isr_lvl_i;
          end
        end
        OP_ROT_SP: begin
          isr_clr    = cmd_oh;
          low_cmd_we = 1'b1;
          low_cmd    = cmd_lvl_i;
        end
        OP_SET_LOW: begin
          low_cmd_we = 1'b1;
          low_cmd    = cmd_lvl_i;
        end
        OP_AROT_ON:  arot_set = 1'b1;
        OP_AROT_OFF: arot_clr = 1'b1;
        default: ;
      endcase
    end
  end

  // command pointer write wins over auto-EOI rotation
  always_comb begin
    low_d = low_q;
    if (low_cmd_we)                      low_d = low_cmd;
    else if (take && auto_eoi_i && arot_q) low_d = win_lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q    <= '0;
      low_q    <= W'(N - 1);
      arot_q   <= 1'b0;
      vector_q <= '0;
      poll_q   <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | (auto_eoi_i ? '0 : win_oh);
      low_q <= low_d;
      if (arot_set)      arot_q <= 1'b1;
      else if (arot_clr) arot_q <= 1'b0;
      if (ack_i) vector_q <= {type_base_i, win_found_i ? win_lvl_i : {W{1'b1}}};
      if (poll_i) poll_q <= win_found_i ? {1'b1, {(7 - W){1'b0}}, win_lvl_i} : 8'h00;
    end
  end

  assign isr_o     = isr_q;
  assign low_o     = low_q;
  assign irr_clr_o = win_oh;
  assign vector_o  = vector_q;
  assign poll_o    = poll_q;

  // R7
  ack_sets_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !auto_eoi_i |=> ((isr_q & $past(win_oh)) == $past(win_oh)));

  // R10
  aeoi_no_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i || poll_i) && auto_eoi_i |=> ((isr_q & ~$past(isr_q)) == '0));

  // R9
  set_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (cmd_i == 3'b110) |=> (low_q == $past(cmd_lvl_i)));

  // R11
  empty_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i && !win_found_i |=> (poll_q == 8'h00));
endmodule

// File: rtl/irq_resolver_core.sv
module irq_resolver_core #(
  parameter int unsigned N_LVL = 8,
  localparam int unsigned LVL_W = $clog2(N_LVL),
  localparam int unsigned TB_W = 8 - LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] irq_i,
  input  logic [N_LVL-1:0] mask_i,
  input  logic             level_mode_i,
  input  logic             auto_eoi_i,
  input  logic             spec_mask_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [LVL_W-1:0] cmd_lvl_i,
  input  logic [TB_W-1:0]  type_base_i,
  input  logic             ack_i,
  input  logic             poll_i,
  output logic             int_o,
  output logic [7:0]       vector_o,
  output logic [7:0]       poll_o
);
  logic [N_LVL-1:0] irr, isr, irr_clr, elig;
  logic [LVL_W-1:0] low, isr_lvl, isr_rank, win_lvl, win_rank;
  logic             isr_found, win_found;

  irq_request_reg #(.N(N_LVL)) u_irr (
    .clk_i, .rst_ni, .irq_i, .level_mode_i,
    .clr_i (irr_clr),
    .irr_o (irr)
  );

  irq_prio_find #(.N(N_LVL)) u_isr_find (
    .vec_i   (isr),
    .low_i   (low),
    .found_o (isr_found),
    .lvl_o   (isr_lvl),
    .rank_o  (isr_rank)
  );

  for (genvar j = 0; j < N_LVL; j++) begin : g_elig
    logic [LVL_W-1:0] rank_j;
    assign rank_j  = LVL_W'(j) - low - LVL_W'(1);
    assign elig[j] = irr[j] & ~mask_i[j] & ~isr[j] &
                     (spec_mask_i | ~isr_found | (rank_j < isr_rank));
  end

  irq_prio_find #(.N(N_LVL)) u_win_find (
    .vec_i   (elig),
    .low_i   (low),
    .found_o (win_found),
    .lvl_o   (win_lvl),
    .rank_o  (win_rank)
  );

  irq_service_ctrl #(.N(N_LVL)) u_svc (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .cmd_lvl_i, .ack_i, .poll_i,
    .auto_eoi_i, .type_base_i,
    .win_found_i (win_found),
    .win_lvl_i   (win_lvl),
    .isr_found_i (isr_found),
    .isr_lvl_i   (isr_lvl),
    .isr_o       (isr),
    .low_o       (low),
    .irr_clr_o   (irr_clr),
    .vector_o,
    .poll_o
  );

  assign int_o = win_found;

  // R4
  int_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~mask_i) != '0));

  // R5
  nested_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o && !spec_mask_i && isr_found |-> (win_rank < isr_rank));

  // R6
  spec_mask_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o && spec_mask_i |-> ((isr & (N_LVL'(1) << win_lvl)) == '0));
endmodule

// File: tb/irq_resolver_core_tb.sv
module irq_resolver_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0, mask = '0;
  logic       level_mode = 1'b0, auto_eoi = 1'b0, spec_mask = 1'b0;
  logic       cmd_valid = 1'b0, ack = 1'b0, poll = 1'b0;
  logic [2:0] cmd = '0, cmd_lvl = '0;
  logic [4:0] tbase = 5'h0A;
  logic       int_w;
  logic [7:0] vec_w, poll_w;

  always #2ns clk = ~clk;

  irq_resolver_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mask_i(mask),
    .level_mode_i(level_mode), .auto_eoi_i(auto_eoi), .spec_mask_i(spec_mask),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .cmd_lvl_i(cmd_lvl), .type_base_i(tbase),
    .ack_i(ack), .poll_i(poll), .int_o(int_w), .vector_o(vec_w), .poll_o(poll_w)
  );

  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";

  // behavioural reference state
  logic [7:0] m_irr, m_isr, m_prev, m_vec, m_poll;
  int         m_lp;
  bit         m_rot;

  task automatic resolve(output int win, output int hi);
    int hi_rank;
    hi = -1; hi_rank = 8; win = -1;
    for (int r = 0; r < 8; r++) begin
      int l;
      l = (m_lp + 1 + r) % 8;
      if (hi < 0 && m_isr[l]) begin hi = l; hi_rank = r; end
    end
    for (int r = 0; r < 8; r++) begin
      int l;
      l = (m_lp + 1 + r) % 8;
      if (win < 0 && m_irr[l] && !mask[l] && !m_isr[l] && (spec_mask || r < hi_rank)) win = l;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_prev = '0; m_vec = '0; m_poll = '0; m_lp = 7; m_rot = 0;
    end else begin
      int w, h, n_lp;
      logic [7:0] clr, setb, n_irr;
      bit take;
      resolve(w, h);
      take  = (ack || poll) && w >= 0;
      n_irr = level_mode ? irq : ((m_irr & ~(take ? 8'(1 << w) : 8'h00)) | (irq & ~m_prev));
      clr = '0; setb = '0; n_lp = m_lp;
      if (take) begin
        if (!auto_eoi) setb[w] = 1'b1;
        else if (m_rot) n_lp = w;
      end
      if (cmd_valid) begin
        case (cmd)
          3'b001: if (h >= 0) clr[h] = 1'b1;
          3'b011: clr[cmd_lvl] = 1'b1;
          3'b101: if (h >= 0) begin clr[h] = 1'b1; n_lp = h; end
          3'b111: begin clr[cmd_lvl] = 1'b1; n_lp = int'(cmd_lvl); end
          3'b110: n_lp = int'(cmd_lvl);
          3'b100: m_rot = 1;
          3'b000: m_rot = 0;
          default: ;
        endcase
      end
      if (ack)  m_vec  = {tbase, (w >= 0) ? 3'(w) : 3'd7};
      if (poll) m_poll = (w >= 0) ? {5'b10000, 3'(w)} : 8'h00;
      m_isr  = (m_isr & ~clr) | setb;
      m_irr  = n_irr;
      m_prev = irq;
      m_lp   = n_lp;
    end
  end

  task automatic compare();
    int w, h;
    resolve(w, h);
    n_cmp++;
    if (int_w !== 1'(w >= 0) || vec_w !== m_vec || poll_w !== m_poll) begin
      n_bad++;
      $display("FAIL %s: int/vector/poll actual=%b/%h/%h expected=%b/%h/%h",
               phase, int_w, vec_w, poll_w, 1'(w >= 0), m_vec, m_poll);
    end
  endtask

  always begin
    @(negedge clk);
    #1ns;
    compare();
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    #0.5ns;
  endtask

  task automatic do_cmd(logic [2:0] c, logic [2:0] l);
    cmd_valid = 1'b1; cmd = c; cmd_lvl = l;
    cyc(1);
    cmd_valid = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic do_poll();
    poll = 1'b1; cyc(1); poll = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    settle();
    chk("R1", "int", {7'b0, int_w}, 8'h00);
    chk("R1", "vector", vec_w, 8'h00);
    chk("R1", "poll", poll_w, 8'h00);

    // R2 / R7 / R5: edge capture, acknowledge, nesting
    phase = "R2";
    irq = 8'h28; cyc(2); settle();
    chk("R4", "int with pending 3,5", {7'b0, int_w}, 8'h01);
    phase = "R7";
    do_ack(); settle();
    chk("R7", "vector of level 3", vec_w, 8'h53);
    cyc(3); settle();
    chk("R5", "level 5 blocked by 3 in service", {7'b0, int_w}, 8'h00);
    phase = "R8";
    do_cmd(3'b001, 3'd0); settle();
    chk("R8", "int after ns-eoi", {7'b0, int_w}, 8'h01);
    do_ack(); settle();
    chk("R2", "held line 3 not relatched, vector 5", vec_w, 8'h55);
    do_cmd(3'b010, 3'd0); settle();
    chk("R8", "nop leaves 5 in service", {7'b0, int_w}, 8'h00);
    do_cmd(3'b001, 3'd0);

    // R4 masking
    phase = "R4";
    irq = 8'h00; cyc(1);
    irq = 8'h81; mask = 8'h01; cyc(1); settle();
    chk("R4", "int with level 7 unmasked", {7'b0, int_w}, 8'h01);
    do_ack(); settle();
    chk("R4", "masked 0 skipped, vector 7", vec_w, 8'h57);
    mask = 8'h00;
    do_ack(); settle();
    chk("R5", "level 0 preempts 7", vec_w, 8'h50);
    do_cmd(3'b001, 3'd0);
    do_cmd(3'b001, 3'd0); settle();
    chk("R8", "two ns-eoi leave nothing", {7'b0, int_w}, 8'h00);

    // R6 special mask
    phase = "R6";
    irq = 8'h00; cyc(1);
    irq = 8'h40; cyc(1);
    do_ack();
    irq = 8'hC0; cyc(1); settle();
    chk("R5", "7 blocked by 6", {7'b0, int_w}, 8'h00);
    spec_mask = 1'b1; cyc(1); settle();
    chk("R6", "7 allowed under special mask", {7'b0, int_w}, 8'h01);
    do_ack(); settle();
    chk("R6", "vector 7", vec_w, 8'h57);
    spec_mask = 1'b0;
    phase = "R8";
    do_cmd(3'b011, 3'd6);
    do_cmd(3'b011, 3'd7);

    // R9 rotation
    phase = "R9";
    do_cmd(3'b110, 3'd2);
    irq = 8'h00; cyc(1);
    irq = 8'h12; cyc(1);
    do_ack(); settle();
    chk("R9", "after lowest=2, level 4 beats 1", vec_w, 8'h54);
    do_cmd(3'b101, 3'd0);
    do_ack(); settle();
    chk("R9", "rotate ns-eoi then level 1", vec_w, 8'h51);
    do_cmd(3'b111, 3'd1);

    // R10 / R11 auto-EOI with rotation and polling
    phase = "R10";
    auto_eoi = 1'b1;
    do_cmd(3'b100, 3'd0);
    irq = 8'h00; cyc(1);
    irq = 8'h08; cyc(1);
    do_ack(); settle();
    chk("R10", "auto-eoi vector 3", vec_w, 8'h53);
    irq = 8'h00; cyc(1);
    irq = 8'h14; cyc(1);
    phase = "R11";
    do_poll(); settle();
    chk("R11", "poll level 4 after rotate to 3", poll_w, 8'h84);
    do_poll(); settle();
    chk("R11", "poll level 2", poll_w, 8'h82);
    do_poll(); settle();
    chk("R11", "empty poll", poll_w, 8'h00);
    phase = "R10";
    do_cmd(3'b000, 3'd0);
    auto_eoi = 1'b0;

    // R12 command and acknowledge together
    phase = "R12";
    do_cmd(3'b110, 3'd7);
    irq = 8'h00; cyc(1);
    irq = 8'h20; cyc(1);
    ack = 1'b1; cmd_valid = 1'b1; cmd = 3'b110; cmd_lvl = 3'd2;
    cyc(1);
    ack = 1'b0; cmd_valid = 1'b0; settle();
    chk("R12", "vector 5 with same-cycle command", vec_w, 8'h55);
    irq = 8'h21; cyc(1); settle();
    chk("R12", "level 0 below 5 after pointer moved to 2", {7'b0, int_w}, 8'h00);
    do_cmd(3'b001, 3'd0);
    do_cmd(3'b110, 3'd7);
    do_ack();
    do_cmd(3'b001, 3'd0);

    // R3 level capture
    phase = "R3";
    irq = 8'h00; level_mode = 1'b1; cyc(1);
    irq = 8'h10; cyc(1); settle();
    chk("R3", "int follows level", {7'b0, int_w}, 8'h01);
    irq = 8'h00; cyc(1); settle();
    chk("R3", "request drops with line", {7'b0, int_w}, 8'h00);
    irq = 8'h10; cyc(1);
    do_ack(); settle();
    chk("R3", "vector 4", vec_w, 8'h54);
    do_cmd(3'b001, 3'd0); settle();
    chk("R3", "held level requests again", {7'b0, int_w}, 8'h01);
    irq = 8'h00; level_mode = 1'b0; cyc(2);

    // mixed traffic against the model
    phase = "R5";
    for (int i = 0; i < 3000; i++) begin
      if (i % 8 == 0) irq = 8'($urandom);
      if (i % 32 == 0) begin
        mask       = 8'($urandom) & 8'($urandom);
        spec_mask  = ($urandom % 4) == 0;
        auto_eoi   = ($urandom % 4) == 0;
        level_mode = ($urandom % 5) == 0;
      end
      cmd_valid = ($urandom % 6) == 0;
      cmd       = 3'($urandom);
      cmd_lvl   = 3'($urandom);
      ack       = ($urandom % 5) == 0;
      poll      = ($urandom % 11) == 0;
      tbase     = 5'($urandom);
      cyc(1);
    end
    cmd_valid = 1'b0; ack = 1'b0; poll = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule